// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the register side of a minimal UART. A processor reaches it through a 32-bit word register bus with an address, single-cycle read and write strobes, write data and combinational read data. On the line side it accepts received bytes through a valid/ready handshake and emits transmitted bytes as one-cycle valid pulses. Baud generation and bit-level serialisation are handled elsewhere. The transmitter here counts as always idle and empty.

Received bytes go into a circular FIFO of parameterised depth, built from a read pointer and a fill count. A read of the data register removes the oldest byte. The interrupt enable register gates two interrupt sources onto one output. The receive source fires while the FIFO holds data. The transmit source fires whenever it is enabled, because the transmit side drains at once. The identify register reports which source wins, with receive taking priority. A write to the identify register can discard the whole receive FIFO. The remaining registers return fixed values so that driver code probing them finds a working, enabled port.

Top module: `mini_uart_regs`

## Requirements
- R1: After reset the FIFO is empty, both interrupt enables are 0, `irq` and `tx_valid` are low, `rx_ready` is high, the enable register at 0x44 reads 0xC0 and the extended status at 0x64 reads 0x30E.
- R2: A write to 0x44 keeps only bit 0 (receive enable) and bit 1 (transmit enable). A read of 0x44 returns those two bits ORed with 0xC0.
- R3: `irq` is high exactly when (receive enable and FIFO not empty) or transmit enable. Address 0x00 reads 1 while `irq` is high and 0 otherwise.
- R4: Address 0x48 reads 0xC0 plus 0x4 when the FIFO holds data, or plus 0x2 when it is empty, with bit 0 also set while `irq` is low.
- R5: A write to 0x48 with bit 1 set empties the FIFO, and a byte offered on the same cycle is discarded. A write to 0x48 with bit 1 clear changes nothing.
- R6: A read of 0x40 returns the byte at the read pointer. If the FIFO is not empty, the read also removes that byte, so bytes leave in arrival order, and the pointer wraps at the depth.
- R7: A read of 0x40 on an empty FIFO returns whatever byte is stored at the read pointer, and the count and the pointer stay as they were.
- R8: A received byte is stored at slot (pointer + count) mod depth. `rx_ready` is low while the count equals the depth, and a byte offered then is not stored.
- R9: Address 0x54 reads 0x60, with bit 0 set while the FIFO holds data.
- R10: Address 0x64 reads 0x30E. While data is present it also sets bit 0 and carries the fill count from bit 16 upward.
- R11: Address 0x04 reads 1 and address 0x60 reads 3. Addresses 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unknown address read 0. Writes to all of these change no state.
- R12: A write to 0x40 drives its low byte on `tx_data`, with `tx_valid` high for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the FIFO after the pointer has been moved off zero. It then drains it, so the wrap of both the write slot and the read pointer is exercised. A design that wrapped at the wrong point would return bytes out of order. It offers a byte while the FIFO is full and reads the empty FIFO once more after draining it. A design that kept the surplus byte, or that moved the pointer on an empty read, would return the wrong data or show a count that is off by one. It also checks the identify encoding with each interrupt source enabled, and writes to the identify register with and without the flush bit, including a flush on the same cycle as a byte arrival. Getting the priority or the bit 0 polarity wrong, or dropping the flush/arrival precedence, would show up as a wrong identify value or a stale fill count.

// File: rtl/mu_regs_pkg.sv
package mu_regs_pkg;

   // Register byte offsets
   localparam logic [7:0] OFF_PEND  = 8'h00;
   localparam logic [7:0] OFF_ENA   = 8'h04;
   localparam logic [7:0] OFF_DATA  = 8'h40;
   localparam logic [7:0] OFF_IEN   = 8'h44;
   localparam logic [7:0] OFF_IDENT = 8'h48;
   localparam logic [7:0] OFF_LCTL  = 8'h4C;
   localparam logic [7:0] OFF_MCTL  = 8'h50;
   localparam logic [7:0] OFF_LSTAT = 8'h54;
   localparam logic [7:0] OFF_MSTAT = 8'h58;
   localparam logic [7:0] OFF_SCR   = 8'h5C;
   localparam logic [7:0] OFF_XCTL  = 8'h60;
   localparam logic [7:0] OFF_XSTAT = 8'h64;
   localparam logic [7:0] OFF_BAUD  = 8'h68;

   // Fixed readback values
   localparam logic [31:0] IEN_FIXED   = 32'h0000_00C0;
   localparam logic [31:0] IDENT_FIXED = 32'h0000_00C0;
   localparam logic [31:0] LSTAT_IDLE  = 32'h0000_0060;
   localparam logic [31:0] XSTAT_IDLE  = 32'h0000_030E;
   localparam logic [31:0] ENA_VALUE   = 32'h0000_0001;
   localparam logic [31:0] XCTL_VALUE  = 32'h0000_0003;
   localparam int          XSTAT_LVL_LSB = 16;

   // Interrupt source bits: bit 0 receive, bit 1 transmit
   typedef struct packed {
      logic tx;
      logic rx;
   } irq_bits_t;

endpackage

// File: rtl/mu_rx_ring.sv
module mu_rx_ring #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop_req,
   input  logic             flush,
   output logic [DW-1:0]    head_data,
   output logic [CNT_W-1:0] count,
   output logic             not_full
);
   localparam int  SUM_W  = CNT_W + 1;
   localparam bit  IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mu_rx_ring: DEPTH must be at least 2");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] nxt_ptr;
   logic [PTR_W-1:0] wr_idx;
   logic [SUM_W-1:0] wr_sum;
   logic [CNT_W-1:0] cnt;
   logic             do_push;
   logic             do_pop;

   assign not_full  = (cnt < CNT_W'(DEPTH));
   assign do_push   = push && not_full && !flush;
   assign do_pop    = pop_req && (cnt != '0);
   assign wr_sum    = SUM_W'(rd_ptr) + SUM_W'(cnt);
   assign head_data = mem[rd_ptr];
   assign count     = cnt;

   // Modulo arithmetic: free wrap for powers of two, compare otherwise
   if (IS_POW2) begin : g_wrap_pow2
      assign wr_idx  = wr_sum[PTR_W-1:0];
      assign nxt_ptr = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_idx  = (wr_sum >= SUM_W'(DEPTH)) ? PTR_W'(wr_sum - SUM_W'(DEPTH))
                                                 : PTR_W'(wr_sum);
      assign nxt_ptr = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_idx] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_pop) rd_ptr <= nxt_ptr;
         if (flush) cnt <= '0;
         else       cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   // R8
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R5
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   // R6
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push && !flush && count != '0) |=> (count == $past(count) - CNT_W'(1)));

   // R7
   empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push && !flush && count == '0) |=> (count == '0 && $stable(rd_ptr)));

endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl
   import mu_regs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ien_we,
   input  logic [1:0] ien_wdata,
   input  logic      rx_nonempty,
   output irq_bits_t ien_q,
   output irq_bits_t pend,
   output logic      irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_we) ien_q <= irq_bits_t'(ien_wdata);
   end

   always_comb begin
      pend.rx = ien_q.rx && rx_nonempty;
      pend.tx = ien_q.tx;
   end

   assign irq = pend.rx || pend.tx;

   // R3
   tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_q.tx |-> irq);

   // R3
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_q.tx && !(ien_q.rx && rx_nonempty)) |-> !irq);

endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
   import mu_regs_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("mini_uart_regs: ADDR_W must cover offset 0x68");
   end
   if (CNT_W > 32 - XSTAT_LVL_LSB) begin : g_bad_level
      $error("mini_uart_regs: fill count does not fit the status word");
   end

   logic             hit_data, hit_ien, hit_ident;
   logic             pop_req, flush, push;
   logic [7:0]       head_data;
   logic [CNT_W-1:0] fill;
   logic             nonempty;
   irq_bits_t        ien_q, pend;
   logic             unused_bits;

   assign hit_data  = (bus_addr == ADDR_W'(OFF_DATA));
   assign hit_ien   = (bus_addr == ADDR_W'(OFF_IEN));
   assign hit_ident = (bus_addr == ADDR_W'(OFF_IDENT));

   assign pop_req  = bus_rd && hit_data;
   assign flush    = bus_wr && hit_ident && bus_wdata[1];
   assign push     = rx_valid && rx_ready;
   assign nonempty = (fill != '0);
   assign unused_bits = ^{bus_wdata[31:8], pend};

   mu_rx_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (rx_data),
      .pop_req   (pop_req),
      .flush     (flush),
      .head_data (head_data),
      .count     (fill),
      .not_full  (rx_ready)
   );

   mu_irq_ctrl u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien_we      (bus_wr && hit_ien),
      .ien_wdata   (bus_wdata[1:0]),
      .rx_nonempty (nonempty),
      .ien_q       (ien_q),
      .pend        (pend),
      .irq         (irq)
   );

   // Transmit: drains at once, one-cycle pulse per data write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= bus_wr && hit_data;
         if (bus_wr && hit_data) tx_data <= bus_wdata[7:0];
      end
   end

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_PEND):  bus_rdata = {31'b0, irq};
         ADDR_W'(OFF_ENA):   bus_rdata = ENA_VALUE;
         ADDR_W'(OFF_DATA):  bus_rdata = {24'b0, head_data};
         ADDR_W'(OFF_IEN):   bus_rdata = IEN_FIXED | {30'b0, ien_q};
         ADDR_W'(OFF_IDENT): bus_rdata = IDENT_FIXED
                                       | (nonempty ? 32'h4 : 32'h2)
                                       | {31'b0, !irq};
         ADDR_W'(OFF_LSTAT): bus_rdata = LSTAT_IDLE | {31'b0, nonempty};
         ADDR_W'(OFF_XCTL):  bus_rdata = XCTL_VALUE;
         ADDR_W'(OFF_XSTAT): bus_rdata = XSTAT_IDLE | {31'b0, nonempty}
                                       | (32'(fill) << XSTAT_LVL_LSB);
         default:            bus_rdata = '0;
      endcase
   end

   // R12
   tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_data) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

   // R12
   tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit_data) |=> !tx_valid);

endmodule

// File: tb/test_mini_uart_regs.sv
module test_mini_uart_regs;
   localparam int CLK_P = 10;
   localparam int DEPTH = 8;
   localparam int AW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          rx_ready, tx_valid, irq;
   logic [7:0]    tx_data;

   always #(CLK_P/2) clk = ~clk;

   mini_uart_regs #(.DEPTH(DEPTH), .ADDR_W(AW)) i_mini_uart_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] val; string tag; } exp_t;
   exp_t       rdq[$];
   logic [7:0] txq[$];

   // Reference model
   logic [7:0] m_mem [DEPTH];
   int         m_rp = 0, m_cnt = 0;
   logic [1:0] m_ien = 2'b00;

   function automatic logic m_irq();
      return (m_ien[0] && m_cnt != 0) || m_ien[1];
   endfunction
   function automatic logic [31:0] m_ident();
      return 32'hC0 | ((m_cnt != 0) ? 32'h4 : 32'h2) | (m_irq() ? 32'h0 : 32'h1);
   endfunction
   function automatic logic [31:0] m_xstat();
      return (m_cnt != 0) ? (32'h30F | (32'(m_cnt) << 16)) : 32'h30E;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitors: pop expected values as results appear
   always @(negedge clk) begin
      if (bus_rd) begin
         if (rdq.size() == 0) chk("read without expectation", 32'd1, 32'd0);
         else begin
            exp_t e;
            e = rdq.pop_front();
            chk(e.tag, bus_rdata, e.val);
         end
      end
   end
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         if (txq.size() == 0) chk("R12 unexpected tx pulse", 32'd1, 32'd0);
         else chk("R12 tx byte", {24'b0, tx_data}, {24'b0, txq.pop_front()});
      end
   end

   // Driver tasks
   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(posedge clk); #1;
      bus_addr = AW'(a); bus_rd = 1'b1;
      rdq.push_back('{exp, tag});
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic rd_data(string tag);
      logic [31:0] e;
      e = {24'b0, m_mem[m_rp]};
      if (m_cnt > 0) begin
         m_cnt--;
         m_rp = (m_rp + 1) % DEPTH;
      end
      rd(8'h40, e, tag);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = AW'(a); bus_wr = 1'b1; bus_wdata = d;
      if (a == 8'h44) m_ien = d[1:0];
      if (a == 8'h48 && d[1]) m_cnt = 0;
      if (a == 8'h40) txq.push_back(d[7:0]);
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic push(logic [7:0] b, string tag);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = b;
      chk(tag, {31'b0, rx_ready}, {31'b0, (m_cnt < DEPTH)});
      if (m_cnt < DEPTH) begin
         m_mem[(m_rp + m_cnt) % DEPTH] = b;
         m_cnt++;
      end
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic probe(string tag);
      @(negedge clk);
      chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq()});
      chk({tag, " rx_ready"}, {31'b0, rx_ready}, {31'b0, (m_cnt < DEPTH)});
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
      chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
      rd(8'h44, 32'hC0, "R1 ien");
      rd(8'h64, 32'h30E, "R1 xstat");
      rd(8'h48, 32'hC3, "R1 ident");

      // R11: fixed and dead registers
      rd(8'h04, 32'h1, "R11 enables");
      rd(8'h60, 32'h3, "R11 xctl");
      rd(8'h4C, 32'h0, "R11 lctl");
      rd(8'h50, 32'h0, "R11 mctl");
      rd(8'h58, 32'h0, "R11 mstat");
      rd(8'h5C, 32'h0, "R11 scratch");
      rd(8'h68, 32'h0, "R11 baud");
      rd(8'h80, 32'h0, "R11 unknown");
      wr(8'h5C, 32'hFFFF_FFFF);
      wr(8'h04, 32'h0);
      wr(8'h60, 32'h0);
      wr(8'h68, 32'h1234);
      rd(8'h5C, 32'h0, "R11 scratch after write");
      rd(8'h04, 32'h1, "R11 enables after write");
      rd(8'h60, 32'h3, "R11 xctl after write");
      rd(8'h44, 32'hC0, "R11 ien untouched");
      probe("R11 after dead writes");

      // R2/R3/R4: enable masking, transmit interrupt
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h44, 32'hC3, "R2 ien mask");
      probe("R3 tx enabled");
      rd(8'h00, 32'h1, "R3 pending reg");
      rd(8'h48, m_ident(), "R4 ident tx only");
      wr(8'h44, 32'h0);
      probe("R3 none enabled");
      rd(8'h00, 32'h0, "R3 pending reg clear");
      rd(8'h48, 32'hC3, "R4 ident idle");

      // R3/R4/R6/R9/R10: receive path
      wr(8'h44, 32'h1);
      probe("R3 rx enabled empty");
      push(8'h11, "R8 ready");
      push(8'h22, "R8 ready");
      push(8'h33, "R8 ready");
      probe("R3 rx pending");
      rd(8'h48, 32'hC4, "R4 ident rx");
      rd(8'h54, 32'h61, "R9 lstat data");
      rd(8'h64, 32'h0003_030F, "R10 xstat level 3");
      rd(8'h00, 32'h1, "R3 pending rx");
      rd_data("R6 first");
      rd_data("R6 second");
      rd_data("R6 third");
      probe("R3 rx drained");
      rd(8'h48, 32'hC3, "R4 ident drained");
      rd(8'h54, 32'h60, "R9 lstat empty");

      // R8/R6: fill from an offset pointer, overflow, wrap
      for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i), "R8 ready while filling");
      probe("R8 full");
      rd(8'h64, m_xstat(), "R10 xstat full");
      push(8'hEE, "R8 ready low when full");
      rd(8'h64, m_xstat(), "R8 no store when full");
      for (int i = 0; i < DEPTH; i++) rd_data("R6 wrap drain");
      // R7: empty read returns stale slot, changes nothing
      rd_data("R7 stale byte");
      rd(8'h64, 32'h30E, "R7 count unchanged");
      rd_data("R7 stale byte again");

      // R5: flush behaviour
      push(8'h5A, "R8 ready");
      push(8'h6B, "R8 ready");
      wr(8'h48, 32'hFFFF_FFFD);
      rd(8'h64, m_xstat(), "R5 no flush without bit1");
      wr(8'h48, 32'h2);
      rd(8'h64, 32'h30E, "R5 flush");
      rd(8'h54, 32'h60, "R5 lstat after flush");
      push(8'h7C, "R8 ready");
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = 8'h99;
      bus_addr = AW'(8'h48); bus_wr = 1'b1; bus_wdata = 32'h2;
      m_cnt = 0;
      @(posedge clk); #1;
      rx_valid = 1'b0; bus_wr = 1'b0;
      rd(8'h64, 32'h30E, "R5 flush beats arrival");
      probe("R5 after flush");

      // R12: transmit pulses
      wr(8'h40, 32'h1234_56A5);
      @(negedge clk);
      @(negedge clk);
      chk("R12 pulse width", {31'b0, tx_valid}, 32'd0);
      wr(8'h40, 32'h0000_003C);
      wr(8'h40, 32'hFFFF_FF00);
      rd(8'h64, 32'h30E, "R12 write leaves rx fifo");

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R12 all tx seen", 32'(txq.size()), 32'd0);
      chk("read queue drained", 32'(rdq.size()), 32'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule